// File: doc/BRIEF.md
# Smart Card Clock and ETU Timing Generator

This block derives the two timing references a smart card reader needs from its system clock. The first is a continuous, square card clock whose half period is set by a card-clock divisor. The second is a one-cycle ETU strobe that marks every elementary time unit; it is set by a separate baud divisor and paces the serial engine for both the transmit and the receive direction.

Both divisors come in on parallel inputs and are captured by a load strobe. Each captured value is held in a shadow stage and goes live only where its own divider completes a period, so a change never produces a runt card clock cycle or a short ETU. After reset the divisors hold a pair that gives 372 card clocks per ETU, which is the rate the card uses for its first answer to reset. Software can retune the ETU once that exchange is over. Clearing the enable parks both dividers. Setting it again restarts them together from a known phase.

Top module: `sc_timing_gen`

## Requirements
- R1: With the active card-clock divisor S, the card clock is high for S+1 system clocks and low for S+1 system clocks, so its period is 2×(S+1).
- R2: With the active baud divisor B, ETU strobes are spaced exactly 2×(B+1) system clocks apart.
- R3: The ETU strobe is high for exactly one system clock per ETU.
- R4: Out of reset the divisors are S = SCC_RST (default 1) and B = 372×(S+1)−1 (default 743), so each ETU spans exactly 372 card clock periods (1488 system clocks).
- R5: A card-clock divisor captured by the load strobe while running takes effect only after the card clock finishes its current period (at its falling edge), so the period in progress keeps the old length.
- R6: A baud divisor captured by the load strobe while running takes effect only at the next ETU strobe, so the ETU in progress keeps the old length.
- R7: While the enable is low the card clock is low and no ETU strobe appears, from the first clock edge at which the low enable is sampled.
- R8: After the enable rises, the card clock first goes high S+1 system clocks later and the first ETU strobe comes 2×(B+1) system clocks later, both counted from the first edge at which the enable is sampled high.
- R9: Divisor values of zero are legal: S = 0 gives a card clock of half the system clock, and B = 0 gives an ETU strobe every second system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Runs both dividers when high; parks them when low |
| clk_div_i | input | DIV_W | Card-clock divisor value to capture |
| baud_div_i | input | DIV_W | Baud divisor value to capture |
| load_i | input | 1 | Captures both divisor inputs into the shadow stage |
| card_clk_o | output | 1 | Square clock for the card |
| etu_pulse_o | output | 1 | One-cycle strobe per elementary time unit |

## Verification
The reset defaults are run and the card clock periods between two strobes are counted. This catches any error in the 372 relation or in the default derivation. Several divisor pairs are then tried: both zero, small odd and even values, and a scaled 372 pair. Measuring the high and low halves separately from the strobe spacing shows whether the two dividers are sized independently and whether a divisor is off by one. Live reloads issued in the middle of a card clock period and in the middle of an ETU show whether the new value waits for the boundary or cuts the current period short. A disable followed by a re-enable confirms that the outputs go quiet and that both phases restart from zero.

// File: rtl/sc_timing_pkg.sv
package sc_timing_pkg;
  localparam int unsigned DIV_W = 16;
  localparam int unsigned ETU_CARD_CLKS = 372;

  // baud divisor giving ETU_CARD_CLKS card clocks per ETU
  function automatic logic [DIV_W-1:0] etu_baud_div(input logic [DIV_W-1:0] scc);
    logic [31:0] v;
    v = ETU_CARD_CLKS * (32'(scc) + 32'd1) - 32'd1;
    return v[DIV_W-1:0];
  endfunction
endpackage

// File: rtl/sc_div_shadow.sv
module sc_div_shadow #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         apply_i,
  output logic [W-1:0] cur_o
);
  logic [W-1:0] pend_q, cur_q;
  logic         pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= RST_VAL;
      cur_q      <= RST_VAL;
      pend_vld_q <= 1'b0;
    end else begin
      if (apply_i && pend_vld_q) cur_q <= pend_q;
      if (load_i) begin
        pend_q     <= val_i;
        pend_vld_q <= 1'b1;
      end else if (apply_i) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/sc_card_clk_div.sv
module sc_card_clk_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         clk_o,
  output logic         period_end_o
);
  logic [W-1:0] cnt_q;
  logic         clk_q;
  logic         half_end;

  assign half_end = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (half_end) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // a period ends where the high half ends
  assign period_end_o = en_i & half_end & clk_q;
  assign clk_o        = clk_q;
endmodule

// File: rtl/sc_etu_div.sv
module sc_etu_div #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         pulse_o,
  output logic         period_end_o
);
  localparam int unsigned CW = W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          pulse_q;
  logic          at_end;

  assign last   = {div_i, 1'b1};  // 2*(div+1)-1
  assign at_end = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (at_end) begin
      cnt_q   <= '0;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end

  assign period_end_o = en_i & at_end;
  assign pulse_o      = pulse_q;
endmodule

// File: rtl/sc_timing_gen.sv
module sc_timing_gen #(
  parameter int unsigned DIV_W = sc_timing_pkg::DIV_W,
  parameter logic [DIV_W-1:0] SCC_RST = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             load_i,
  output logic             card_clk_o,
  output logic             etu_pulse_o
);
  localparam logic [DIV_W-1:0] BAUD_RST =
    DIV_W'((sc_timing_pkg::ETU_CARD_CLKS * (32'(SCC_RST) + 32'd1)) - 32'd1);

  logic [DIV_W-1:0] scc_cur, baud_cur;
  logic             scc_end, baud_end;

  sc_div_shadow #(.W(DIV_W), .RST_VAL(SCC_RST)) u_scc_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .val_i  (clk_div_i),
    .apply_i(scc_end | ~en_i),
    .cur_o  (scc_cur)
  );

  sc_div_shadow #(.W(DIV_W), .RST_VAL(BAUD_RST)) u_baud_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .val_i  (baud_div_i),
    .apply_i(baud_end | ~en_i),
    .cur_o  (baud_cur)
  );

  sc_card_clk_div #(.W(DIV_W)) u_card_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .div_i       (scc_cur),
    .clk_o       (card_clk_o),
    .period_end_o(scc_end)
  );

  sc_etu_div #(.W(DIV_W)) u_etu_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .div_i       (baud_cur),
    .pulse_o     (etu_pulse_o),
    .period_end_o(baud_end)
  );
endmodule

// File: rtl/sc_timing_gen_chk.sv
module sc_timing_gen_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         card_clk_o,
  input logic         etu_pulse_o,
  input logic [W-1:0] scc_cur,
  input logic [W-1:0] baud_cur
);
  logic [W:0]   hold_q;
  logic [W+1:0] gap_q;
  logic         clk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      gap_q   <= '0;
      clk_d_q <= 1'b0;
    end else begin
      clk_d_q <= card_clk_o;
      hold_q  <= (!en_i || card_clk_o != clk_d_q) ? '0 : hold_q + 1'b1;
      gap_q   <= (!en_i || etu_pulse_o) ? '0 : gap_q + 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    etu_pulse_o |=> !etu_pulse_o); // R3

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!card_clk_o && !etu_pulse_o)); // R7

  AST_HALF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> (hold_q <= {1'b0, $past(scc_cur)} + 1'b1)); // R1

  AST_ETU_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> (gap_q <= {1'b0, $past(baud_cur), 1'b0} + 2'd2)); // R2
endmodule

bind sc_timing_gen sc_timing_gen_chk #(.W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .card_clk_o (card_clk_o),
  .etu_pulse_o(etu_pulse_o),
  .scc_cur    (scc_cur),
  .baud_cur   (baud_cur)
);

// File: tb/sc_timing_gen_tb_top.sv
`timescale 1ns/1ps
module sc_timing_gen_tb_top;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] clk_div_i = '0;
  logic [W-1:0] baud_div_i = '0;
  logic         load_i = 1'b0;
  logic         card_clk_o, etu_pulse_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  sc_timing_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .clk_div_i(clk_div_i), .baud_div_i(baud_div_i), .load_i(load_i),
    .card_clk_o(card_clk_o), .etu_pulse_o(etu_pulse_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!etu_pulse_o && n < 20000);
  endtask

  task automatic wait_clk(input logic lvl, output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (card_clk_o !== lvl && n < 20000);
  endtask

  // stop, load a divisor pair, restart; check start phase, spacing and halves
  task automatic run_pair(input int s, input int b, input string tag);
    int n, first_hi, first_p, h, l;
    @(negedge clk_i); en_i = 1'b0;
    clk_div_i = W'(s); baud_div_i = W'(b); load_i = 1'b1;
    @(negedge clk_i); load_i = 1'b0;
    repeat (3) @(negedge clk_i);
    en_i = 1'b1;
    n = 0; first_hi = -1; first_p = -1;
    while ((first_hi < 0 || first_p < 0) && n < 20000) begin
      @(negedge clk_i); n++;
      if (card_clk_o && first_hi < 0) first_hi = n;
      if (etu_pulse_o && first_p < 0) first_p = n;
    end
    check({"R8 first card clock high ", tag}, first_hi, s + 1);
    check({"R8 first ETU strobe ", tag}, first_p, 2 * (b + 1));
    if (first_p > first_hi) wait_pulse(n);
    wait_pulse(n);
    check({"R2 ETU spacing ", tag}, n, 2 * (b + 1));
    wait_clk(1'b0, n); wait_clk(1'b1, n);
    wait_clk(1'b0, h); wait_clk(1'b1, l);
    check({"R1 high half ", tag}, h, s + 1);
    check({"R1 low half ", tag}, l, s + 1);
  endtask

  task automatic count_clks_per_etu(input string tag);
    int n, rises;
    logic prev;
    wait_pulse(n);
    rises = 0; prev = card_clk_o;
    do begin
      @(negedge clk_i);
      if (card_clk_o && !prev) rises++;
      prev = card_clk_o;
    end while (!etu_pulse_o);
    check({"R4 card clocks per ETU ", tag}, rises, 372);
  endtask

  task automatic t_reset;
    check("R7 card clock low in reset", int'(card_clk_o), 0);
    check("R7 no strobe in reset", int'(etu_pulse_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    check("R7 card clock low while disabled", int'(card_clk_o), 0);
    check("R7 no strobe while disabled", int'(etu_pulse_o), 0);
  endtask

  task automatic t_defaults;
    int n, h, l;
    @(negedge clk_i); en_i = 1'b1;
    wait_pulse(n);
    check("R4 R8 first ETU at defaults", n, 1488);
    @(negedge clk_i);
    check("R3 strobe one cycle wide", int'(etu_pulse_o), 0);
    wait_pulse(n);
    check("R2 R4 ETU spacing at defaults", n + 1, 1488);
    count_clks_per_etu("defaults");
    wait_clk(1'b0, n); wait_clk(1'b1, n);
    wait_clk(1'b0, h); wait_clk(1'b1, l);
    check("R1 R4 default high half", h, 2);
    check("R1 R4 default low half", l, 2);
  endtask

  task automatic t_pairs;
    run_pair(0, 0, "R9 S0 B0");
    run_pair(2, 9, "S2 B9");
    run_pair(4, 7, "S4 B7");
    run_pair(3, 372 * 4 - 1, "S3 scaled");
    count_clks_per_etu("S3 scaled");
  endtask

  task automatic t_live_clk;
    int n, c, f1, f2;
    logic prev;
    run_pair(3, 50, "before clk reload");
    wait_clk(1'b1, n); wait_clk(1'b0, n);  // just past a fall
    c = 0; f1 = -1; f2 = -1; prev = card_clk_o;
    while (f2 < 0 && c < 200) begin
      @(negedge clk_i); c++;
      if (c == 1) begin clk_div_i = W'(1); baud_div_i = W'(50); load_i = 1'b1; end
      if (c == 2) load_i = 1'b0;
      if (!card_clk_o && prev) begin
        if (f1 < 0) f1 = c; else f2 = c;
      end
      prev = card_clk_o;
    end
    check("R5 period in progress keeps old length", f1, 8);
    check("R5 next period uses new divisor", f2 - f1, 4);
  endtask

  task automatic t_live_baud;
    int n, c, p1, p2;
    run_pair(0, 20, "before baud reload");
    wait_pulse(n);
    c = 0; p1 = -1; p2 = -1;
    while (p2 < 0 && c < 500) begin
      @(negedge clk_i); c++;
      if (c == 5) begin clk_div_i = '0; baud_div_i = W'(5); load_i = 1'b1; end
      if (c == 6) load_i = 1'b0;
      if (etu_pulse_o) begin
        if (p1 < 0) p1 = c; else p2 = c;
      end
    end
    check("R6 ETU in progress keeps old length", p1, 42);
    check("R6 next ETU uses new divisor", p2 - p1, 12);
  endtask

  task automatic t_disable;
    int n, viol;
    run_pair(2, 3, "before disable");
    wait_clk(1'b1, n);
    en_i = 1'b0;
    viol = 0;
    repeat (60) begin
      @(negedge clk_i);
      if (card_clk_o || etu_pulse_o) viol++;
    end
    check("R7 outputs quiet after disable", viol, 0);
    run_pair(2, 3, "after re-enable");
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_pairs();
    t_live_clk();
    t_live_baud();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule